// File: doc/BRIEF.md
# Ticket Vending Controller

This block is the control state machine of a five-button movie ticket vending machine. Each button input is a debounced pulse that lasts one clock cycle. The customer steps through a title stage, a quantity stage and a payment stage, then sees a timed change stage. In the title stage, left and right step through four titles. In the quantity stage, up and down set the number of tickets. Enter confirms each of these two stages. In the payment stage the four direction buttons each stand for a bill of a fixed value.

All money is held as a count of half-dollar units. The amount due is the price of the chosen title times the quantity. When the running total paid reaches the amount due or passes it, the block computes the change and enters a five-second change stage. In that stage a display enable flashes at a half-second pace. When it ends, the machine returns to a fresh title stage. A prescaled tick counts the timing, and its dividers are parameters, so a bench can use a short window.

Top module: `ticket_vend_fsm`

## Requirements
- R1: After reset: stage is 0 (title), title is DEFAULT_MOVIE (0), quantity is 1, paid is 0, change is 0 and disp_on is 1.
- R2: In stage 0, a right pulse steps the title up by one and a left pulse steps it down by one, wrapping between 3 and 0. Up and down have no effect. Enter moves to stage 1 (quantity) with quantity 1.
- R3: In stage 1, up raises the quantity and down lowers it, saturating at 4 and at 1. Left and right have no effect. Enter moves to stage 2 (payment) with paid 0.
- R4: The due output always equals price(title) × quantity, in half-dollar units. The default prices are 36, 27, 18 and 24 for titles 0 to 3.
- R5: In stage 2, up adds 2, down adds 10, left adds 20 and right adds 40 to paid. Enter has no effect.
- R6: On the edge where paid becomes at least due, stage becomes 3 (change) and change equals the new paid minus due.
- R7: Stage 3 lasts TICK_DIV×HALF_TICKS×BLINK_HALVES cycles. disp_on is 1 in its first TICK_DIV×HALF_TICKS cycles and inverts after each further span of that length. Outside stage 3, disp_on is 1.
- R8: When stage 3 ends, stage is 0, the title is DEFAULT_MOVIE, the quantity is 1, and paid and change are 0.
- R9: Button pulses during stage 3 change no output and do not alter the timing.
- R10: In every stage, a cycle in which more than one button input is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| btn_up | input | 1 | Up pulse |
| btn_down | input | 1 | Down pulse |
| btn_left | input | 1 | Left pulse |
| btn_right | input | 1 | Right pulse |
| btn_enter | input | 1 | Enter pulse |
| stage | output | 2 | 0 title, 1 quantity, 2 payment, 3 change |
| movie | output | 2 | Selected title |
| qty | output | 3 | Ticket quantity |
| due | output | MONEY_W | Amount due, half-dollar units |
| paid | output | MONEY_W | Amount paid, half-dollar units |
| change | output | MONEY_W | Change, half-dollar units |
| disp_on | output | 1 | Display enable (flashes in stage 3) |

## Verification
Assertions check several invariants on every cycle:
- The quantity stays in range.
- Stages only advance in order.
- Paid never drops during payment and stays below due while payment is open.
- Change matches paid minus due throughout stage 3.
- Title, quantity and paid stay frozen in stage 3 and are cleared on its exit.

Some behaviour only the bench's scenarios can show: the exact length of the flashing window, the phase of each inversion, title wraparound, the bill values, and the rejection of cycles with more than one button.

// File: rtl/ticket_vend_fsm.sv
module ticket_vend_fsm #(
  parameter int TICK_DIV      = 1_000_000,
  parameter int HALF_TICKS    = 50,
  parameter int BLINK_HALVES  = 10,
  parameter int DEFAULT_MOVIE = 0,
  parameter int PRICE_0       = 36,
  parameter int PRICE_1       = 27,
  parameter int PRICE_2       = 18,
  parameter int PRICE_3       = 24,
  parameter int MONEY_W       = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               btn_up,
  input  logic               btn_down,
  input  logic               btn_left,
  input  logic               btn_right,
  input  logic               btn_enter,
  output logic [1:0]         stage,
  output logic [1:0]         movie,
  output logic [2:0]         qty,
  output logic [MONEY_W-1:0] due,
  output logic [MONEY_W-1:0] paid,
  output logic [MONEY_W-1:0] change,
  output logic               disp_on
);
  localparam int CYC_W  = $clog2(TICK_DIV + 1);
  localparam int TCK_W  = $clog2(HALF_TICKS + 1);
  localparam int HLF_W  = $clog2(BLINK_HALVES + 1);
  localparam logic [1:0] DEF_MV = 2'(DEFAULT_MOVIE);

  typedef enum logic [1:0] {ST_SEL = 2'd0, ST_QTY = 2'd1, ST_PAY = 2'd2, ST_CHG = 2'd3} st_t;

  st_t               st_q;
  logic [1:0]        movie_q;
  logic [2:0]        qty_q;
  logic [MONEY_W-1:0] paid_q, chg_q;
  logic              disp_q;
  logic [CYC_W-1:0]  cyc_q;
  logic [TCK_W-1:0]  tck_q;
  logic [HLF_W-1:0]  hlf_q;

  wire [4:0] btns    = {btn_enter, btn_right, btn_left, btn_down, btn_up};
  wire       one_btn = $onehot(btns);

  int price_sel;
  always_comb begin
    case (movie_q)
      2'd0:    price_sel = PRICE_0;
      2'd1:    price_sel = PRICE_1;
      2'd2:    price_sel = PRICE_2;
      default: price_sel = PRICE_3;
    endcase
  end

  assign due = MONEY_W'(price_sel * int'(qty_q));

  logic [MONEY_W:0] bill, sum;
  always_comb begin
    if (btn_up)         bill = (MONEY_W+1)'(2);
    else if (btn_down)  bill = (MONEY_W+1)'(10);
    else if (btn_left)  bill = (MONEY_W+1)'(20);
    else                bill = (MONEY_W+1)'(40);
    sum = {1'b0, paid_q} + bill;
  end

  wire tick     = (cyc_q == CYC_W'(TICK_DIV - 1));
  wire half_end = tick && (tck_q == TCK_W'(HALF_TICKS - 1));
  wire last_hlf = (hlf_q == HLF_W'(BLINK_HALVES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_SEL;
      movie_q <= DEF_MV;
      qty_q   <= 3'd1;
      paid_q  <= '0;
      chg_q   <= '0;
      disp_q  <= 1'b1;
      cyc_q   <= '0;
      tck_q   <= '0;
      hlf_q   <= '0;
    end else begin
      case (st_q)
        ST_SEL: if (one_btn) begin
          if (btn_right) movie_q <= movie_q + 2'd1;
          if (btn_left)  movie_q <= movie_q - 2'd1;
          if (btn_enter) begin
            st_q  <= ST_QTY;
            qty_q <= 3'd1;
          end
        end
        ST_QTY: if (one_btn) begin
          if (btn_up && qty_q != 3'd4)   qty_q <= qty_q + 3'd1;
          if (btn_down && qty_q != 3'd1) qty_q <= qty_q - 3'd1;
          if (btn_enter) begin
            st_q   <= ST_PAY;
            paid_q <= '0;
          end
        end
        ST_PAY: if (one_btn && !btn_enter) begin
          paid_q <= sum[MONEY_W-1:0];
          if (sum >= {1'b0, due}) begin
            st_q   <= ST_CHG;
            chg_q  <= sum[MONEY_W-1:0] - due;
            disp_q <= 1'b1;
            cyc_q  <= '0;
            tck_q  <= '0;
            hlf_q  <= '0;
          end
        end
        default: begin
          if (!tick) cyc_q <= cyc_q + CYC_W'(1);
          else begin
            cyc_q <= '0;
            if (!half_end) tck_q <= tck_q + TCK_W'(1);
            else begin
              tck_q  <= '0;
              disp_q <= ~disp_q;
              if (!last_hlf) hlf_q <= hlf_q + HLF_W'(1);
              else begin
                hlf_q   <= '0;
                st_q    <= ST_SEL;
                movie_q <= DEF_MV;
                qty_q   <= 3'd1;
                paid_q  <= '0;
                chg_q   <= '0;
                disp_q  <= 1'b1;
              end
            end
          end
        end
      endcase
    end
  end

  assign stage   = st_q;
  assign movie   = movie_q;
  assign qty     = qty_q;
  assign paid    = paid_q;
  assign change  = chg_q;
  assign disp_on = disp_q;

  AST_QTY_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (qty_q >= 3'd1) && (qty_q <= 3'd4)); // R3
  AST_SEL_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SEL) |=> (st_q == ST_SEL || st_q == ST_QTY)); // R2
  AST_QTY_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_QTY) |=> (st_q == ST_QTY || st_q == ST_PAY)); // R3
  AST_PAY_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_PAY) |=> (st_q == ST_PAY || st_q == ST_CHG)); // R6
  AST_PAID_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_PAY) |=> (paid_q >= $past(paid_q))); // R5
  AST_PAY_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_PAY) |-> (paid_q < due)); // R6
  AST_CHANGE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_CHG) |-> (chg_q == paid_q - due)); // R6
  AST_CHG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_CHG) |=> (st_q == ST_SEL) || ($stable(paid_q) && $stable(movie_q) && $stable(qty_q))); // R9
  AST_EXIT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_CHG) |=> (st_q == ST_CHG) || (paid_q == '0 && chg_q == '0 && qty_q == 3'd1 && disp_q)); // R8
  AST_DISP_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_CHG) |-> disp_q); // R7
endmodule

// File: tb/test_ticket_vend_fsm.sv
module test_ticket_vend_fsm;
  localparam int TD = 4, HT = 3, BH = 10;
  localparam int HALF_CYC = TD * HT;
  localparam int WIN = HALF_CYC * BH;

  logic clk = 1'b0, rst_n = 1'b0;
  logic b_up = 0, b_dn = 0, b_lf = 0, b_rt = 0, b_en = 0;
  logic [1:0] stage, movie;
  logic [2:0] qty;
  logic [7:0] due, paid, change;
  logic disp_on;

  always #2 clk = ~clk;

  ticket_vend_fsm #(.TICK_DIV(TD), .HALF_TICKS(HT), .BLINK_HALVES(BH)) i_ticket_vend_fsm (
    .clk(clk), .rst_n(rst_n), .btn_up(b_up), .btn_down(b_dn), .btn_left(b_lf),
    .btn_right(b_rt), .btn_enter(b_en), .stage(stage), .movie(movie), .qty(qty),
    .due(due), .paid(paid), .change(change), .disp_on(disp_on));

  int n_chk = 0, n_fail = 0;
  int m_stage, m_movie, m_qty, m_paid, m_change;

  function automatic int price_of(int mv);
    case (mv)
      0: return 36;
      1: return 27;
      2: return 18;
      default: return 24;
    endcase
  endfunction

  function automatic int bill_of(logic [4:0] m);
    if (m[0]) return 2;
    if (m[1]) return 10;
    if (m[2]) return 20;
    return 40;
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    chk(tag, "stage", stage, m_stage);
    chk(tag, "movie", movie, m_movie);
    chk(tag, "qty", qty, m_qty);
    chk(tag, "paid", paid, m_paid);
    chk(tag, "change", change, m_change);
    chk("R4", "due", due, price_of(m_movie) * m_qty);
    chk("R7", "disp_on", disp_on, 1);
  endtask

  task automatic model_reset();
    m_stage = 0; m_movie = 0; m_qty = 1; m_paid = 0; m_change = 0;
  endtask

  task automatic drive(logic [4:0] m);
    {b_en, b_rt, b_lf, b_dn, b_up} = m;
  endtask

  // mask bits: 0 up, 1 down, 2 left, 3 right, 4 enter
  task automatic press(logic [4:0] m, string tag);
    drive(m);
    @(negedge clk);
    drive(5'd0);
    if ($countones(m) == 1) begin
      case (m_stage)
        0: begin
          if (m[3]) m_movie = (m_movie + 1) % 4;
          if (m[2]) m_movie = (m_movie + 3) % 4;
          if (m[4]) begin m_stage = 1; m_qty = 1; end
        end
        1: begin
          if (m[0] && m_qty < 4) m_qty++;
          if (m[1] && m_qty > 1) m_qty--;
          if (m[4]) begin m_stage = 2; m_paid = 0; end
        end
        2: if (!m[4]) begin
          m_paid += bill_of(m);
          if (m_paid >= price_of(m_movie) * m_qty) begin
            m_stage = 3;
            m_change = m_paid - price_of(m_movie) * m_qty;
          end
        end
        default: ;
      endcase
    end
    if (m_stage == 3) begin
      chk(tag, "stage", stage, 3);
      chk("R6", "change", change, m_change);
      chk(tag, "paid", paid, m_paid);
    end else check_all(tag);
  endtask

  task automatic run_blink(bit noisy);
    for (int k = 1; k <= WIN; k++) begin
      if (noisy && ($urandom % 3 == 0)) drive(5'($urandom));
      @(negedge clk);
      drive(5'd0);
      if (k < WIN) begin
        chk("R7", "stage", stage, 3);
        chk("R7", "disp_on", disp_on, ((k / HALF_CYC) % 2 == 0) ? 1 : 0);
        chk("R9", "paid", paid, m_paid);
        chk("R9", "change", change, m_change);
        chk("R9", "movie", movie, m_movie);
        chk("R9", "qty", qty, m_qty);
      end else begin
        model_reset();
        check_all("R8");
      end
    end
  endtask

  function automatic logic [4:0] rand_mask(int multi_pct);
    if (int'($urandom % 100) < multi_pct) return 5'b00011 << ($urandom % 4);
    return 5'b00001 << ($urandom % 4);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    repeat (3) @(negedge clk);
    check_all("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1");

    press(5'b00100, "R2");
    press(5'b01000, "R2");
    press(5'b01000, "R2");
    press(5'b01000, "R2");
    press(5'b01000, "R2");
    press(5'b00001, "R2");
    press(5'b00010, "R2");
    press(5'b01100, "R10");
    press(5'b11000, "R10");
    press(5'b10000, "R2");
    for (int i = 0; i < 5; i++) press(5'b00001, "R3");
    press(5'b00100, "R3");
    press(5'b01000, "R3");
    press(5'b00011, "R10");
    for (int i = 0; i < 5; i++) press(5'b00010, "R3");
    press(5'b00001, "R3");
    press(5'b10000, "R3");
    press(5'b10000, "R5");
    press(5'b00110, "R10");
    press(5'b01000, "R5");
    press(5'b01000, "R6");
    run_blink(1'b1);

    // exact payment: title 2 (18) x 1, pay 10 + 2x4
    press(5'b00100, "R2");
    press(5'b00100, "R2");
    press(5'b10000, "R2");
    press(5'b10000, "R3");
    press(5'b00010, "R5");
    for (int i = 0; i < 4; i++) press(5'b00001, "R5");
    chk("R6", "exact change", change, 0);
    run_blink(1'b0);

    for (int c = 0; c < 30; c++) begin
      for (int i = 0; i < int'($urandom % 7); i++) press(rand_mask(15), "R2");
      press(5'b10000, "R2");
      for (int i = 0; i < int'($urandom % 7); i++) press(rand_mask(15), "R3");
      press(5'b10000, "R3");
      while (m_stage == 2) press(($urandom % 8 == 0) ? 5'b10000 : rand_mask(10), "R5");
      run_blink(1'b1);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule